// File: doc/BRIEF.md
# Pointer-Addressed Register-File Load/Store Unit

This block is the execute and writeback slice of a 32-bit core whose working storage is a 512-word register file. It handles two instructions that use register contents as addresses into that same register file. The first is a pointer read, which fills a destination register from the word a pointer selects. The second is a pointer write, which puts a value at the word that the destination register points to. Either one moves a full 32-bit word per instruction, and the core issues one instruction per clock.

The register file lives outside the block. The unit drives three combinational read addresses and receives the read data: destination field, source field, and the indirect pointer. It presents a registered write port one cycle after issue, and the surrounding core commits that write on the next edge. A result that is still waiting in the write port is forwarded into every read, and the pending Z update is forwarded into condition evaluation. An instruction that follows a pointer change therefore needs no delay slot.

Top module: `ls_unit`

## Requirements
- R1: A write happens only for an issued word with opcode bits [31:26] = 000110 and bit 23 = 1. Bit 24 = 0 selects the pointer read and bit 24 = 1 selects the pointer write. Any other word, or issue_i low, causes no register write and no Z update.
- R2: Pointer read with bit 22 = 0 writes the register named by bits [17:9] with the word at the address held in the register named by bits [8:0].
- R3: Pointer read with bit 22 = 1 writes the register named by bits [17:9] with the word at address bits [8:0] itself.
- R4: Pointer write with bit 22 = 0 stores the value of the register named by bits [8:0] at the address held in the register named by bits [17:9].
- R5: Pointer write with bit 22 = 1 stores bits [8:0], zero-extended to 32 bits, at the address held in the register named by bits [17:9].
- R6: Only bits [8:0] of a pointer register form the address; bits [31:9] have no effect.
- R7: The write port (wr_en_o, wr_addr_o, wr_data_o) and the Z update (z_we_o, z_val_o) appear in the cycle after issue, and back-to-back issue is sustained.
- R8: Every instruction sees the results of all earlier ones with no gap: a pointer, a data word or a location changed by the previous instruction is read at its new value.
- R9: With bit 25 = 1, an executed instruction asserts z_we_o, and z_val_o is 1 exactly when the written word is zero. With bit 25 = 0, Z is left alone. Bit 24 never produces any carry-flag update.
- R10: The instruction executes only if condition bits [21:18] have bit index 2*C+Z set, where Z includes the update from the previous instruction. On failure nothing is written and Z is unchanged.
- R11: After reset, no write and no Z update are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_i | input | 1 | An instruction is presented this cycle |
| instr_i | input | 32 | Decoded instruction word |
| flag_c_i | input | 1 | Architectural carry flag |
| flag_z_i | input | 1 | Architectural zero flag (committed state) |
| rd_a_addr_o | output | 9 | Read address: destination field |
| rd_a_data_i | input | 32 | Read data for port A |
| rd_b_addr_o | output | 9 | Read address: source field |
| rd_b_data_i | input | 32 | Read data for port B |
| rd_c_addr_o | output | 9 | Read address: indirect pointer for the read |
| rd_c_data_i | input | 32 | Read data for port C |
| wr_en_o | output | 1 | Register-file write enable |
| wr_addr_o | output | 9 | Register-file write address |
| wr_data_o | output | 32 | Register-file write data |
| z_we_o | output | 1 | Z flag update enable |
| z_val_o | output | 1 | New Z value |

## Verification
The bench builds the unit with its default 32-bit word and 9-bit address, so the full 512-word space and the 23 ignored pointer bits are all live. The register file is preloaded so that most pointers land in a hot window of 32 words and their upper bits carry noise. The random stream draws its fields from that same window. This makes back-to-back pointer and data hazards frequent, and the forwarding paths and the ignored upper bits are exercised thousands of times rather than by chance.

// File: rtl/ls_pkg.sv
package ls_pkg;

  localparam int unsigned LS_XLEN   = 32;
  localparam int unsigned LS_AW     = 9;
  localparam int unsigned LS_OPCODE = 6;

  typedef enum logic [1:0] {
    LS_NONE  = 2'd0,
    LS_LOAD  = 2'd1,
    LS_STORE = 2'd2
  } ls_kind_e;

  // Condition nibble: bit index 2*C+Z selects whether to execute.
  function automatic logic ls_cond_pass(input logic [3:0] cc, input logic c, input logic z);
    return cc[{c, z}];
  endfunction

  function automatic logic ls_is_zero32(input logic [LS_XLEN-1:0] v);
    return (v == '0);
  endfunction

endpackage

// File: rtl/ls_decode.sv
module ls_decode
  import ls_pkg::*;
#(
  parameter int unsigned XLEN   = LS_XLEN,
  parameter int unsigned AW     = LS_AW,
  parameter int unsigned OPCODE = LS_OPCODE
) (
  input  logic            issue,
  input  logic [XLEN-1:0] instr,
  output ls_kind_e        kind,
  output logic            imm,
  output logic            wz,
  output logic [3:0]      cond,
  output logic [AW-1:0]   dfld,
  output logic [AW-1:0]   sfld
);
  localparam int unsigned P_COND = 2 * AW;
  localparam int unsigned P_IMM  = P_COND + 4;
  localparam int unsigned P_RES  = P_IMM + 1;
  localparam int unsigned P_SEL  = P_RES + 1;
  localparam int unsigned P_ZW   = P_SEL + 1;
  localparam int unsigned OPW    = XLEN - P_ZW - 1;

  logic op_hit;

  assign op_hit = (instr[XLEN-1 -: OPW] == OPW'(OPCODE));
  assign imm    = instr[P_IMM];
  assign wz     = instr[P_ZW];
  assign cond   = instr[P_COND +: 4];
  assign dfld   = instr[AW +: AW];
  assign sfld   = instr[0 +: AW];

  always_comb begin
    kind = LS_NONE;
    if (issue && op_hit && instr[P_RES]) begin
      kind = instr[P_SEL] ? LS_STORE : LS_LOAD;
    end
  end

endmodule

// File: rtl/ls_bypass.sv
module ls_bypass
  import ls_pkg::*;
#(
  parameter int unsigned XLEN = LS_XLEN,
  parameter int unsigned AW   = LS_AW
) (
  input  logic [AW-1:0]   raddr,
  input  logic [XLEN-1:0] rdata,
  input  logic            wb_en,
  input  logic [AW-1:0]   wb_addr,
  input  logic [XLEN-1:0] wb_data,
  output logic [XLEN-1:0] data
);
  // A write still sitting in the output register is newer than the file.
  assign data = (wb_en && (wb_addr == raddr)) ? wb_data : rdata;
endmodule

// File: rtl/ls_exec.sv
module ls_exec
  import ls_pkg::*;
#(
  parameter int unsigned XLEN = LS_XLEN,
  parameter int unsigned AW   = LS_AW
) (
  input  ls_kind_e        kind,
  input  logic            imm,
  input  logic            wz,
  input  logic [3:0]      cond,
  input  logic [AW-1:0]   dfld,
  input  logic [AW-1:0]   sfld,
  input  logic [AW-1:0]   a_ptr,
  input  logic [XLEN-1:0] b_val,
  input  logic [XLEN-1:0] c_val,
  input  logic            flag_c,
  input  logic            flag_z,
  output logic [AW-1:0]   load_ptr,
  output logic            cond_ok,
  output logic            go,
  output logic [AW-1:0]   nxt_addr,
  output logic [XLEN-1:0] nxt_data,
  output logic            nxt_zwe,
  output logic            nxt_zval
);
  logic [XLEN-1:0] imm_ext;

  assign imm_ext  = {{(XLEN-AW){1'b0}}, sfld};
  assign load_ptr = imm ? sfld : b_val[AW-1:0];
  assign cond_ok  = ls_cond_pass(cond, flag_c, flag_z);
  assign go       = (kind != LS_NONE) && cond_ok;

  always_comb begin
    if (kind == LS_STORE) begin
      nxt_addr = a_ptr;
      nxt_data = imm ? imm_ext : b_val;
    end else begin
      nxt_addr = dfld;
      nxt_data = c_val;
    end
  end

  assign nxt_zwe  = go && wz;
  assign nxt_zval = (nxt_data == '0);

endmodule

// File: rtl/ls_unit.sv
module ls_unit
  import ls_pkg::*;
#(
  parameter int unsigned XLEN   = LS_XLEN,
  parameter int unsigned AW     = LS_AW,
  parameter int unsigned OPCODE = LS_OPCODE
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_i,
  input  logic [XLEN-1:0] instr_i,
  input  logic            flag_c_i,
  input  logic            flag_z_i,
  output logic [AW-1:0]   rd_a_addr_o,
  input  logic [XLEN-1:0] rd_a_data_i,
  output logic [AW-1:0]   rd_b_addr_o,
  input  logic [XLEN-1:0] rd_b_data_i,
  output logic [AW-1:0]   rd_c_addr_o,
  input  logic [XLEN-1:0] rd_c_data_i,
  output logic            wr_en_o,
  output logic [AW-1:0]   wr_addr_o,
  output logic [XLEN-1:0] wr_data_o,
  output logic            z_we_o,
  output logic            z_val_o
);
  ls_kind_e        kind;
  logic            imm, wz;
  logic [3:0]      cond;
  logic [AW-1:0]   dfld, sfld, load_ptr, nxt_addr;
  logic [XLEN-1:0] fwd_a, fwd_b, fwd_c, nxt_data;
  logic            cond_ok, go, nxt_zwe, nxt_zval, z_eff, is_store;

  ls_decode #(.XLEN(XLEN), .AW(AW), .OPCODE(OPCODE)) u_dec (
    .issue(issue_i), .instr(instr_i), .kind(kind), .imm(imm), .wz(wz),
    .cond(cond), .dfld(dfld), .sfld(sfld)
  );

  assign rd_a_addr_o = dfld;
  assign rd_b_addr_o = sfld;
  assign rd_c_addr_o = load_ptr;
  assign is_store    = (kind == LS_STORE);

  ls_bypass #(.XLEN(XLEN), .AW(AW)) u_byp_a (
    .raddr(rd_a_addr_o), .rdata(rd_a_data_i), .wb_en(wr_en_o),
    .wb_addr(wr_addr_o), .wb_data(wr_data_o), .data(fwd_a)
  );
  ls_bypass #(.XLEN(XLEN), .AW(AW)) u_byp_b (
    .raddr(rd_b_addr_o), .rdata(rd_b_data_i), .wb_en(wr_en_o),
    .wb_addr(wr_addr_o), .wb_data(wr_data_o), .data(fwd_b)
  );
  ls_bypass #(.XLEN(XLEN), .AW(AW)) u_byp_c (
    .raddr(rd_c_addr_o), .rdata(rd_c_data_i), .wb_en(wr_en_o),
    .wb_addr(wr_addr_o), .wb_data(wr_data_o), .data(fwd_c)
  );

  // Pending Z update is newer than the committed flag.
  assign z_eff = z_we_o ? z_val_o : flag_z_i;

  ls_exec #(.XLEN(XLEN), .AW(AW)) u_exe (
    .kind(kind), .imm(imm), .wz(wz), .cond(cond), .dfld(dfld), .sfld(sfld),
    .a_ptr(fwd_a[AW-1:0]), .b_val(fwd_b), .c_val(fwd_c),
    .flag_c(flag_c_i), .flag_z(z_eff),
    .load_ptr(load_ptr), .cond_ok(cond_ok), .go(go),
    .nxt_addr(nxt_addr), .nxt_data(nxt_data), .nxt_zwe(nxt_zwe), .nxt_zval(nxt_zval)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      z_we_o    <= 1'b0;
      z_val_o   <= 1'b0;
    end else begin
      wr_en_o <= go;
      z_we_o  <= nxt_zwe;
      if (go) begin
        wr_addr_o <= nxt_addr;
        wr_data_o <= nxt_data;
        z_val_o   <= nxt_zval;
      end
    end
  end

endmodule

// File: rtl/ls_unit_chk.sv
module ls_unit_chk #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned AW     = 9,
  parameter int unsigned OPCODE = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            issue_i,
  input logic [XLEN-1:0] instr_i,
  input logic            cond_ok,
  input logic            go,
  input logic            is_store,
  input logic [XLEN-1:0] fwd_a,
  input logic [AW-1:0]   rd_a_addr_o,
  input logic            wr_en_o,
  input logic [AW-1:0]   wr_addr_o,
  input logic [XLEN-1:0] wr_data_o,
  input logic            z_we_o,
  input logic            z_val_o
);
  localparam int unsigned P_RES = 2 * AW + 5;
  localparam int unsigned OPW   = XLEN - 2 * AW - 8;

  assert_write_after_issue_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> $past(issue_i));

  assert_decode_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> $past((instr_i[XLEN-1 -: OPW] == OPW'(OPCODE)) && instr_i[P_RES]));

  assert_cond_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && !cond_ok) |=> (!wr_en_o && !z_we_o));

  assert_z_needs_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    z_we_o |-> wr_en_o);

  assert_z_matches_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    z_we_o |-> (z_val_o == (wr_data_o == '0)));

  assert_store_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (go && is_store) |=> (wr_addr_o == $past(fwd_a[AW-1:0])));

  assert_forward_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && (rd_a_addr_o == wr_addr_o)) |-> (fwd_a == wr_data_o));

endmodule

bind ls_unit ls_unit_chk #(.XLEN(XLEN), .AW(AW), .OPCODE(OPCODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .instr_i(instr_i),
  .cond_ok(cond_ok), .go(go), .is_store(is_store), .fwd_a(fwd_a),
  .rd_a_addr_o(rd_a_addr_o), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o),
  .wr_data_o(wr_data_o), .z_we_o(z_we_o), .z_val_o(z_val_o)
);

// File: tb/ls_unit_tb.sv
module ls_unit_tb;
  localparam int XLEN  = 32;
  localparam int AW    = 9;
  localparam int DEPTH = 512;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic            rst_n, issue_i, flag_c_i, flag_z_i;
  logic [XLEN-1:0] instr_i, rd_a_data_i, rd_b_data_i, rd_c_data_i, wr_data_o;
  logic [AW-1:0]   rd_a_addr_o, rd_b_addr_o, rd_c_addr_o, wr_addr_o;
  logic            wr_en_o, z_we_o, z_val_o;

  ls_unit u_dut (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .instr_i(instr_i),
    .flag_c_i(flag_c_i), .flag_z_i(flag_z_i),
    .rd_a_addr_o(rd_a_addr_o), .rd_a_data_i(rd_a_data_i),
    .rd_b_addr_o(rd_b_addr_o), .rd_b_data_i(rd_b_data_i),
    .rd_c_addr_o(rd_c_addr_o), .rd_c_data_i(rd_c_data_i),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .z_we_o(z_we_o), .z_val_o(z_val_o)
  );

  // Surrounding core: register file and Z flag committed from the DUT.
  logic [XLEN-1:0] rf [DEPTH];
  logic            zreg;
  assign rd_a_data_i = rf[rd_a_addr_o];
  assign rd_b_data_i = rf[rd_b_addr_o];
  assign rd_c_data_i = rf[rd_c_addr_o];
  assign flag_z_i    = zreg;
  always @(posedge clk) begin
    if (wr_en_o) rf[wr_addr_o] <= wr_data_o;
    if (z_we_o)  zreg <= z_val_o;
  end

  // Architectural reference model.
  logic [XLEN-1:0] mrf [DEPTH];
  logic            mz;
  logic            have_exp, e_en, e_zwe, e_zval;
  logic [AW-1:0]   e_addr;
  logic [XLEN-1:0] e_data;
  string           e_tag;
  int              n_cmp = 0, n_bad = 0;
  bit              done = 0;

  function automatic logic [31:0] mk(input logic [5:0] op, input logic zw, input logic sel,
                                     input logic res, input logic im, input logic [3:0] cc,
                                     input logic [8:0] d, input logic [8:0] s);
    return {op, zw, sel, res, im, cc, d, s};
  endfunction

  task automatic model(input logic iss, input logic [31:0] ins, input logic c);
    logic [8:0] ptr;
    e_en = 1'b0; e_zwe = 1'b0; e_zval = 1'b0; e_addr = '0; e_data = '0;
    e_tag = "R1";
    if (iss && ins[31:26] == 6'b000110 && ins[23]) begin
      if (!ins[18 + {c, mz}]) begin
        e_tag = "R10";
      end else begin
        if (!ins[24]) begin
          ptr    = ins[22] ? ins[8:0] : mrf[ins[8:0]][8:0];
          e_addr = ins[17:9];
          e_data = mrf[ptr];
          e_tag  = ins[22] ? "R3" : "R2";
          if (!ins[22] && mrf[ins[8:0]][31:9] != 0) e_tag = {e_tag, " R6"};
        end else begin
          e_addr = mrf[ins[17:9]][8:0];
          e_data = ins[22] ? {23'b0, ins[8:0]} : mrf[ins[8:0]];
          e_tag  = ins[22] ? "R5" : "R4";
          if (mrf[ins[17:9]][31:9] != 0) e_tag = {e_tag, " R6"};
        end
        e_en = 1'b1;
        if (ins[25]) begin
          e_zwe  = 1'b1;
          e_zval = (e_data == 0);
          mz     = e_zval;
          e_tag  = {e_tag, " R9"};
        end
        mrf[e_addr] = e_data;
      end
    end
    e_tag = {e_tag, " R8"};
  endtask

  task automatic compare();
    bit bad;
    if (!have_exp) return;
    n_cmp++;
    bad = (wr_en_o !== e_en) || (z_we_o !== e_zwe) ||
          (e_en && ((wr_addr_o !== e_addr) || (wr_data_o !== e_data))) ||
          (e_zwe && (z_val_o !== e_zval));
    if (bad) begin
      n_bad++;
      $display("FAIL R7 %s: got en=%0b addr=%0d data=%h zwe=%0b z=%0b, expected en=%0b addr=%0d data=%h zwe=%0b z=%0b",
               e_tag, wr_en_o, wr_addr_o, wr_data_o, z_we_o, z_val_o,
               e_en, e_addr, e_data, e_zwe, e_zval);
    end
  endtask

  task automatic step(input logic iss, input logic [31:0] ins, input logic c);
    @(negedge clk);
    compare();
    issue_i = iss; instr_i = ins; flag_c_i = c;
    model(iss, ins, c);
    have_exp = 1'b1;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    have_exp = 1'b0; rst_n = 1'b0; issue_i = 1'b0; instr_i = '0; flag_c_i = 1'b0;
    zreg = 1'b0; mz = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      logic [31:0] v;
      v = $urandom;
      if (i % 4 == 0) v = '0;
      else if (i % 3 != 0) v[8:0] = 9'((i * 7 + 3) % 32);
      rf[i] = v; mrf[i] = v;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: nothing pending straight out of reset
    n_cmp++;
    if (wr_en_o !== 1'b0 || z_we_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R11: got en=%0b zwe=%0b, expected 0 0", wr_en_o, z_we_o);
    end
    rst_n = 1'b1;

    // R2, R3, R4, R5 directed, with back-to-back pointer hazards (R8)
    step(1, mk(6'b000110, 0, 0, 1, 0, 4'hF, 9'd10, 9'd20), 0);
    step(1, mk(6'b000110, 0, 0, 1, 1, 4'hF, 9'd11, 9'd5),  0);
    step(1, mk(6'b000110, 0, 1, 1, 0, 4'hF, 9'd10, 9'd11), 0);
    step(1, mk(6'b000110, 1, 1, 1, 1, 4'hF, 9'd12, 9'd0),  0);
    step(1, mk(6'b000110, 1, 0, 1, 0, 4'hF, 9'd13, 9'd10), 0);
    step(1, mk(6'b000110, 1, 1, 1, 1, 4'hF, 9'd13, 9'd300), 1);
    step(1, mk(6'b000110, 0, 0, 1, 0, 4'hF, 9'd14, 9'd13), 0);

    // R10: every condition code against every C/Z combination
    for (int zz = 0; zz < 2; zz++) begin
      step(1, mk(6'b000110, 1, 0, 1, 1, 4'hF, 9'd40, zz ? 9'd0 : 9'd1), 0);
      for (int cc = 0; cc < 16; cc++) begin
        for (int c = 0; c < 2; c++) begin
          step(1, mk(6'b000110, 0, 0, 1, 1, 4'(cc), 9'd41, 9'(cc + 2)), c[0]);
        end
      end
    end

    // R1: neighbouring encodings and idle issue leave everything alone
    step(1, mk(6'b000111, 1, 1, 1, 1, 4'hF, 9'd3, 9'd0), 0);
    step(1, mk(6'b000110, 1, 1, 0, 1, 4'hF, 9'd3, 9'd0), 0);
    step(1, mk(6'b000110, 1, 0, 0, 0, 4'hF, 9'd3, 9'd7), 0);
    step(0, mk(6'b000110, 1, 1, 1, 1, 4'hF, 9'd3, 9'd0), 0);
    step(1, mk(6'b000110, 0, 0, 1, 0, 4'hF, 9'd15, 9'd3), 0);

    // Random stream over a hot window (R6, R7, R8, R9)
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] ins;
      ins = $urandom;
      if ($urandom % 8 != 0) ins[31:26] = 6'b000110;
      if ($urandom % 4 != 0) begin
        ins[17:9] = 9'($urandom % 32);
        ins[8:0]  = 9'($urandom % 32);
      end
      if ($urandom % 3 != 0) ins[21:18] = 4'hF;
      step(($urandom % 10) != 0, ins, 1'($urandom));
    end
    step(0, '0, 0);
    step(0, '0, 0);
    @(negedge clk);

    // R8: committed register file and Z equal the architectural state
    for (int i = 0; i < DEPTH; i++) begin
      n_cmp++;
      if (rf[i] !== mrf[i]) begin
        n_bad++;
        $display("FAIL R8 word %0d: got %h, expected %h", i, rf[i], mrf[i]);
      end
    end
    n_cmp++;
    if (zreg !== mz) begin
      n_bad++;
      $display("FAIL R9 final Z: got %0b, expected %0b", zreg, mz);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule